// File: doc/BRIEF.md
# PWM Output Steering Unit

This block takes one pulse-width-modulated waveform and routes it to any subset of four output pins. Each pin has its own steering enable. A pin that is steered on follows the PWM input. A pin that is steered off drives its general-purpose port data bit instead. Generating the PWM waveform, dead-band insertion and polarity control are handled elsewhere.

Software changes the steering through a single-cycle write strobe. The strobe carries the four enables and a timing-mode bit.

- **Immediate mode:** the new enables apply straight after the write, even in the middle of a period. This can cut a pulse short on a pin that is switched.
- **Deferred mode:** the new enables are parked in a pending register. They are copied to the active register on the next period-start pulse, so a switched pin only ever shows whole periods.

The control pins are plain level and pulse signals. No data stream crosses the block edge, so there is no valid/ready handshake and no back-pressure.

Top module: `pwm_steer`

## Requirements
- R1: After reset, pin A (enable bit 0) is steered on and pins B, C and D are off. The pending and active enables both equal 4'b0001, and the timing mode is immediate.
- R2: A pin whose active enable is 1 drives `pwm_in` combinationally, in the same cycle.
- R3: A pin whose active enable is 0 drives its own `port_dout` bit combinationally, in the same cycle.
- R4: A write with `cfg_sync`=0 makes the written enables active at the clock edge that accepts the write, whether or not a period boundary is near.
- R5: A write with `cfg_sync`=1 leaves the active enables unchanged. The written value becomes active at the clock edge that samples the next `period_start` pulse that arrives without a write.
- R6: With `cfg_sync`=1, a second write before the boundary replaces the pending value, and only the latest value is applied.
- R7: The timing mode carried by a write governs that same write. A deferred write issued while the previous mode was immediate is still deferred.
- R8: With no write and no `period_start` pulse, the active enables hold their value.
- R8 (continued): A deferred write in the same cycle as `period_start` waits for the following pulse.
- R9: Enable bit i controls `pin_out[i]` and selects `port_dout[i]`, with A = bit 0 through D = bit 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Single-cycle steering write strobe |
| cfg_steer | input | 4 | Written steering enables, bit i for pin i |
| cfg_sync | input | 1 | Timing mode of this write: 0 immediate, 1 deferred to period start |
| pwm_in | input | 1 | PWM waveform to be routed |
| period_start | input | 1 | One-cycle pulse at the start of each PWM period |
| port_dout | input | 4 | Port data bits for pins that are steered off |
| pin_out | output | 4 | Pin drive, bit 0 = A through bit 3 = D |

## Verification
The pin multiplexer has no register, so pin values are checked one time unit after the inputs change, inside the same low clock phase.

A steering write changes the active enables at the first rising edge that samples the strobe. An immediate write is therefore checked at the next falling edge. A deferred write is checked at that falling edge to confirm nothing moved, then checked again at the falling edge after the edge that sampled `period_start`.

All stimulus is applied on falling edges. Every sample is taken while the clock is low, so no check races a register update.

// File: rtl/pwm_steer_pkg.sv
package pwm_steer_pkg;
  localparam int unsigned PIN_COUNT = 4;
  typedef logic [PIN_COUNT-1:0] steer_t;
  localparam steer_t STEER_RESET = steer_t'(1);
  typedef enum logic { MODE_IMMEDIATE = 1'b0, MODE_DEFERRED = 1'b1 } mode_e;
endpackage

// File: rtl/pwm_steer_regs.sv
module pwm_steer_regs
  import pwm_steer_pkg::*;
#(
  parameter int unsigned NPINS = PIN_COUNT,
  parameter logic [NPINS-1:0] RST_VAL = NPINS'(1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [NPINS-1:0] wr_steer,
  input  logic             wr_sync,
  input  logic             boundary,
  output logic [NPINS-1:0] active_q
);
  logic [NPINS-1:0] pending_q;
  mode_e            mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= RST_VAL;
      active_q  <= RST_VAL;
      mode_q    <= MODE_IMMEDIATE;
    end else if (wr_en) begin
      pending_q <= wr_steer;
      mode_q    <= mode_e'(wr_sync);
      if (!wr_sync) active_q <= wr_steer;
    end else if (boundary && mode_q == MODE_DEFERRED) begin
      active_q <= pending_q;
    end
  end

  // R4: an immediate write is live on the next cycle
  a_r4_immediate_apply: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sync) |=> active_q == $past(wr_steer));
  // R5, R7: a deferred write never moves the active enables by itself
  a_r5_deferred_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sync) |=> active_q == $past(active_q));
  // R5, R6: the boundary installs the last pending value
  a_r6_boundary_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && boundary && mode_q == MODE_DEFERRED) |=> active_q == $past(pending_q));
  // R8: quiet cycles keep the active enables
  a_r8_quiet_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !boundary) |=> $stable(active_q));
endmodule

// File: rtl/pwm_steer_mux.sv
module pwm_steer_mux #(
  parameter int unsigned NPINS = 4
) (
  input  logic [NPINS-1:0] sel,
  input  logic             wave,
  input  logic [NPINS-1:0] gpio,
  output logic [NPINS-1:0] drive
);
  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    assign drive[i] = sel[i] ? wave : gpio[i];
  end
endmodule

// File: rtl/pwm_steer.sv
module pwm_steer
  import pwm_steer_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [PIN_COUNT-1:0] cfg_steer,
  input  logic                 cfg_sync,
  input  logic                 pwm_in,
  input  logic                 period_start,
  input  logic [PIN_COUNT-1:0] port_dout,
  output logic [PIN_COUNT-1:0] pin_out
);
  steer_t active;

  pwm_steer_regs #(.NPINS(PIN_COUNT), .RST_VAL(STEER_RESET)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_we),
    .wr_steer (cfg_steer),
    .wr_sync  (cfg_sync),
    .boundary (period_start),
    .active_q (active)
  );

  pwm_steer_mux #(.NPINS(PIN_COUNT)) u_mux (
    .sel   (active),
    .wave  (pwm_in),
    .gpio  (port_dout),
    .drive (pin_out)
  );
endmodule

// File: tb/pwm_steer_test.sv
module pwm_steer_test;
  localparam time CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [3:0] cfg_steer = 4'h0;
  logic       cfg_sync = 1'b0;
  logic       pwm_in = 1'b0;
  logic       period_start = 1'b0;
  logic [3:0] port_dout = 4'h0;
  logic [3:0] pin_out;

  int n_checks = 0;
  int n_errors = 0;

  pwm_steer uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_steer(cfg_steer),
    .cfg_sync(cfg_sync), .pwm_in(pwm_in), .period_start(period_start),
    .port_dout(port_dout), .pin_out(pin_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // Reads the active enables at the pins: wave high, port data low.
  task automatic get_active(output logic [3:0] a);
    pwm_in = 1'b1; port_dout = 4'h0; #1;
    a = pin_out;
  endtask

  task automatic do_write(input logic [3:0] s, input logic sync, input logic ps);
    @(negedge clk);
    cfg_we = 1'b1; cfg_steer = s; cfg_sync = sync; period_start = ps;
    @(negedge clk);
    cfg_we = 1'b0; period_start = 1'b0;
  endtask

  task automatic pulse_period();
    @(negedge clk); period_start = 1'b1;
    @(negedge clk); period_start = 1'b0;
  endtask

  task automatic t_reset();
    logic [3:0] a;
    get_active(a);
    check("R1 reset steering", a, 4'b0001);
  endtask

  task automatic t_mux();
    logic [3:0] a;
    do_write(4'b0101, 1'b0, 1'b0);
    pwm_in = 1'b1; port_dout = 4'b1010; #1;
    check("R2 on pins follow pwm high", pin_out, 4'b1111);
    pwm_in = 1'b0; #1;
    check("R2 on pins follow pwm low", pin_out, 4'b1010);
    port_dout = 4'b0000; #1;
    check("R3 off pins follow port data", pin_out, 4'b0000);
    do_write(4'b1000, 1'b0, 1'b0);
    pwm_in = 1'b1; port_dout = 4'b0000; #1;
    check("R9 enable bit 3 drives pin D", pin_out, 4'b1000);
    pwm_in = 1'b0; port_dout = 4'b0101; #1;
    check("R9 port bit i on pin i", pin_out, 4'b0101);
    get_active(a);
  endtask

  task automatic t_immediate();
    logic [3:0] a;
    do_write(4'b0110, 1'b0, 1'b0);
    get_active(a);
    check("R4 immediate write mid period", a, 4'b0110);
  endtask

  task automatic t_deferred();
    logic [3:0] a;
    do_write(4'b1001, 1'b1, 1'b0);
    get_active(a);
    check("R7 deferred write held after immediate mode", a, 4'b0110);
    repeat (3) @(negedge clk);
    get_active(a);
    check("R8 quiet cycles hold steering", a, 4'b0110);
    pulse_period();
    get_active(a);
    check("R5 applied at period start", a, 4'b1001);
  endtask

  task automatic t_replace();
    logic [3:0] a;
    do_write(4'b0011, 1'b1, 1'b0);
    do_write(4'b1100, 1'b1, 1'b0);
    get_active(a);
    check("R6 nothing applied before boundary", a, 4'b1001);
    pulse_period();
    get_active(a);
    check("R6 latest pending applied", a, 4'b1100);
  endtask

  task automatic t_coincide();
    logic [3:0] a;
    do_write(4'b0111, 1'b1, 1'b1);
    get_active(a);
    check("R8 write on boundary waits", a, 4'b1100);
    pulse_period();
    get_active(a);
    check("R5 applied at following boundary", a, 4'b0111);
  endtask

  task automatic t_back_immediate();
    logic [3:0] a;
    do_write(4'b0000, 1'b0, 1'b0);
    get_active(a);
    check("R7 immediate write after deferred mode", a, 4'b0000);
    pwm_in = 1'b1; port_dout = 4'b1001; #1;
    check("R3 all pins on port data", pin_out, 4'b1001);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mux();
    t_immediate();
    t_deferred();
    t_replace();
    t_coincide();
    t_back_immediate();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule